// File: doc/BRIEF.md
# Alternating Read/Write Start Arbiter

This block decides, one cycle at a time, whether a burst memory with separate read and write ports begins a read burst, a write burst, or nothing. On every rising clock edge it samples a read-request and a write-request input. It compares them with the start it granted on the previous edge and with how long each port stays occupied. From that it raises at most one single-cycle start strobe in the following cycle. Each burst holds its port for `BURST_CYCLES` cycles (two by default). A request of the same kind that arrives while its port is still occupied is dropped and not remembered.

When both requests are present, the winner depends on history. The read side wins when nothing started on the previous edge, or when a write started there. The write side wins when a read started there. Holding both requests high from idle therefore gives read, write, read, write, and so on. A busy output per port covers the start cycle and the rest of that burst, so the burst datapaths downstream can follow the grants.

Top module: `rw_start_arbiter`

## Requirements
- R1: Reset, asynchronous and active low, clears both start strobes and both busy flags to 0 and clears the history to "nothing started". The first dual request after reset is therefore granted to the read side.
- R2: In no cycle are the read-start and write-start outputs high together.
- R3: If both requests are sampled high and nothing started on the previous edge, the read starts.
- R4: If both requests are sampled high and a read started on the previous edge, the write starts.
- R5: If both requests are sampled high and a write started on the previous edge, the read starts.
- R6: Holding both requests high from idle gives strictly alternating starts that begin with a read. Over 2N cycles that is N reads and N writes.
- R7: With the default two-cycle burst, a lone request of the same kind as the start granted on the previous edge is not granted. A request held high alone is granted on every other cycle.
- R8: A dropped request is discarded, not queued. Once the request input falls, no late start appears for it.
- R9: A start strobe is high for exactly the one cycle after the sampling edge. The matching busy output is high in that cycle and in the following `BURST_CYCLES`-1 cycles, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; requests are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdSel | input | 1 | Read request for the current cycle |
| wrSel | input | 1 | Write request for the current cycle |
| rdStart | output | 1 | One-cycle strobe: a read burst begins |
| wrStart | output | 1 | One-cycle strobe: a write burst begins |
| rdBusy | output | 1 | Read port occupied by a burst |
| wrBusy | output | 1 | Write port occupied by a burst |

## Verification
A request sampled on a rising edge shows up as a start strobe in the cycle that follows that edge, one register later. The matching busy flag rises in the same cycle and stays high for one further cycle. The bench drives requests on the falling edge. On the next falling edge it advances a behavioural model by the one rising edge in between and compares all four outputs there, so each result is checked in exactly the cycle it is due. Start counts per phase are also collected, to confirm the alternating pattern and that dropped requests never come back.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;
  // Strobes from the decision logic to the state-holding datapath
  typedef struct packed {
    logic rd;
    logic wr;
  } startReq_t;

  localparam int PORT_RD = 0;
  localparam int PORT_WR = 1;
  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/rwarb_ctrl.sv
module rwarb_ctrl
  import rwarb_pkg::*;
(
  input  logic      rdSel,
  input  logic      wrSel,
  input  logic      rdFree,
  input  logic      wrFree,
  input  logic      lastWasRead,
  output startReq_t go
);
  logic rdOk;
  logic wrOk;

  assign rdOk = rdSel && rdFree;
  assign wrOk = wrSel && wrFree;

  always_comb begin
    go = '0;
    if (rdOk && wrOk) begin
      // history decides: write only right after a read
      if (lastWasRead) go.wr = 1'b1;
      else             go.rd = 1'b1;
    end else if (rdOk) begin
      go.rd = 1'b1;
    end else if (wrOk) begin
      go.wr = 1'b1;
    end
  end
endmodule

// File: rtl/rwarb_datapath.sv
module rwarb_datapath
  import rwarb_pkg::*;
#(
  parameter int BURST_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  startReq_t go,
  output logic      rdStart,
  output logic      wrStart,
  output logic      rdBusy,
  output logic      wrBusy,
  output logic      rdFree,
  output logic      wrFree
);
  localparam int CW = $clog2(BURST_CYCLES + 1);

  logic [NUM_PORTS-1:0] goVec;
  logic [NUM_PORTS-1:0] startVec;
  logic [NUM_PORTS-1:0] busyVec;
  logic [NUM_PORTS-1:0] freeVec;

  assign goVec[PORT_RD] = go.rd;
  assign goVec[PORT_WR] = go.wr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [CW-1:0] cyclesLeft;
    logic          startR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cyclesLeft <= '0;
        startR     <= 1'b0;
      end else begin
        startR <= goVec[p];
        if (goVec[p])               cyclesLeft <= CW'(BURST_CYCLES);
        else if (cyclesLeft != '0)  cyclesLeft <= cyclesLeft - 1'b1;
      end
    end

    assign startVec[p] = startR;
    assign busyVec[p]  = (cyclesLeft != '0);
    // port can take a new burst next cycle once at most one cycle remains
    assign freeVec[p]  = (cyclesLeft <= CW'(1));
  end

  assign rdStart = startVec[PORT_RD];
  assign wrStart = startVec[PORT_WR];
  assign rdBusy  = busyVec[PORT_RD];
  assign wrBusy  = busyVec[PORT_WR];
  assign rdFree  = freeVec[PORT_RD];
  assign wrFree  = freeVec[PORT_WR];
endmodule

// File: rtl/rw_start_arbiter.sv
module rw_start_arbiter
  import rwarb_pkg::*;
#(
  parameter int BURST_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdSel,
  input  logic wrSel,
  output logic rdStart,
  output logic wrStart,
  output logic rdBusy,
  output logic wrBusy
);
  startReq_t go;
  logic rdFree;
  logic wrFree;

  rwarb_ctrl u_ctrl (
    .rdSel       (rdSel),
    .wrSel       (wrSel),
    .rdFree      (rdFree),
    .wrFree      (wrFree),
    .lastWasRead (rdStart),
    .go          (go)
  );

  rwarb_datapath #(.BURST_CYCLES(BURST_CYCLES)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .rdStart (rdStart),
    .wrStart (wrStart),
    .rdBusy  (rdBusy),
    .wrBusy  (wrBusy),
    .rdFree  (rdFree),
    .wrFree  (wrFree)
  );
endmodule

// File: rtl/rwarb_chk.sv
module rwarb_chk (
  input logic clk,
  input logic rst_n,
  input logic rdSel,
  input logic wrSel,
  input logic rdStart,
  input logic wrStart,
  input logic rdBusy,
  input logic wrBusy
);
  // R2
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdStart, wrStart}));

  // R3
  idle_read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel && !rdBusy && !wrBusy) |=> rdStart);

  // R4
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStart && wrSel && !wrBusy) |=> wrStart);

  // R5
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStart && rdSel && !rdBusy) |=> rdStart);

  // R7
  no_back_to_back_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdStart |=> !rdStart);

  // R7
  no_back_to_back_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStart |=> !wrStart);

  // R9
  rd_busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdStart |-> rdBusy);

  // R9
  wr_busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStart |-> wrBusy);
endmodule

bind rw_start_arbiter rwarb_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rdSel   (rdSel),
  .wrSel   (wrSel),
  .rdStart (rdStart),
  .wrStart (wrStart),
  .rdBusy  (rdBusy),
  .wrBusy  (wrBusy)
);

// File: tb/rw_start_arbiter_tb.sv
module rw_start_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdSel = 1'b0;
  logic wrSel = 1'b0;
  logic rdStart, wrStart, rdBusy, wrBusy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curTag = "R1";

  // model history: 0 none, 1 read, 2 write (newest first)
  int hist0 = 0;
  int hist1 = 0;
  int phRd = 0;
  int phWr = 0;

  rw_start_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .rdSel(rdSel), .wrSel(wrSel),
    .rdStart(rdStart), .wrStart(wrStart), .rdBusy(rdBusy), .wrBusy(wrBusy)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cycles);
      report();
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: advance model over the rising edge just passed, compare, drive next inputs
  task automatic cyc(input logic r, input logic w, input logic rst);
    int nxt;
    @(negedge clk);
    if (!rst_n) begin
      hist0 = 0; hist1 = 0;
    end else begin
      nxt = 0;
      if (rdSel && wrSel)  nxt = (hist0 == 1) ? 2 : 1;
      else if (rdSel)      nxt = (hist0 == 1) ? 0 : 1;
      else if (wrSel)      nxt = (hist0 == 2) ? 0 : 2;
      hist1 = hist0;
      hist0 = nxt;
    end
    check(curTag, "starts{rd,wr}", {rdStart, wrStart}, {hist0 == 1, hist0 == 2});
    check("R9", "busy{rd,wr}", {rdBusy, wrBusy},
          {(hist0 == 1) || (hist1 == 1), (hist0 == 2) || (hist1 == 2)});
    if (rdStart && wrStart) check("R2", "both strobes", 1, 0);
    phRd += int'(rdStart);
    phWr += int'(wrStart);
    rdSel = r; wrSel = w; rst_n = rst;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    // R1: reset state
    curTag = "R1";
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    idle(2);

    // R3: dual request from idle -> read
    curTag = "R3";
    phRd = 0; phWr = 0;
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);
    check("R3", "read starts from idle", phRd, 1);
    check("R3", "write starts from idle", phWr, 0);

    // R6 with R4/R5: held dual requests alternate
    curTag = "R6";
    phRd = 0; phWr = 0;
    cyc(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 19; i++) cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);
    check("R6", "alternating read count", phRd, 10);
    check("R6", "alternating write count", phWr, 10);

    // R4: read then write requested together, write follows read
    curTag = "R4";
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);

    // R5: write then dual -> read
    curTag = "R5";
    phRd = 0; phWr = 0;
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);
    check("R5", "read after write", phRd, 1);

    // R7: lone read held -> every other cycle
    curTag = "R7";
    phRd = 0; phWr = 0;
    cyc(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);
    check("R7", "lone read held 6 cycles", phRd, 3);
    phWr = 0;
    cyc(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(3);
    check("R7", "lone write held 4 cycles", phWr, 2);

    // R8: dropped requests not queued
    curTag = "R8";
    phRd = 0; phWr = 0;
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(5);
    check("R8", "read pulse of 2 cycles", phRd, 1);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(5);
    check("R8", "write pulse of 2 cycles", phWr, 1);

    // R1: reset during traffic, then history is clear (dual -> read)
    curTag = "R1";
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    idle(2);
    phRd = 0; phWr = 0;
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    idle(2);
    check("R1", "first dual grant after reset is read", phRd, 1);
    check("R1", "no write after reset dual", phWr, 0);

    report();
  end
endmodule